// File: doc/BRIEF.md
# DMA Staging FIFO with Occupancy Reporting

This block is the byte-granular staging buffer that sits between the device port and the memory port of one DMA channel. Words enter on a valid/ready push port and leave on a valid/ready pop port. Each side has its own width setting of 8, 16 or 32 bits, so a stream can be packed or unpacked between port widths. Byte swapping can be applied on the memory side, on the device side, or on both.

A direction input selects the transfer direction. In device-to-memory mode the push port is the device side. In memory-to-device mode the push port is the memory side.

Software sees a single count word that reports the free byte slots and the filled bytes together. A device-side byte counter runs alongside it. From the counter and the occupancy, software can bound how far the memory side has progressed. For inbound data, bytes delivered to memory are the device count less the fill. For outbound data, bytes fetched from memory are the device count plus the fill.

A flush input empties the buffer at once. An abort input freezes both ports and keeps the contents. A stop input closes the push port, lets the buffer drain and then raises a stopped flag.

Top module: `dma_stage_fifo`

## Requirements
- R1: `count_reg` carries the free byte slots in bits 23:16 and the filled bytes in bits 7:0, with all other bits zero. Free plus filled always equals DEPTH (64 by default). After reset the buffer is empty.
- R2: A side's size code selects its width: 1 = 8 bits, 2 = 16 bits, 3 = 32 bits. Code 0 holds that port idle. Bytes use data lanes from bits 7:0 upward and leave in the order they entered. Unused output lanes read zero.
- R3: `in_ready` is low when fewer free slots exist than the push width needs. `out_valid` is low when fewer bytes are held than the pop width needs. Neither the fill nor the device counter changes on such a cycle.
- R4: A push and a pop in the same cycle change the fill by the pushed byte count minus the popped byte count.
- R5: `dev_count` counts every byte crossing the device side. That side is the push port when `dir_d2m`=1 and the pop port when `dir_d2m`=0. A write through `dcnt_we` loads `dcnt_wdata` (a write of 0 zeroes it), and the write wins over a transfer in the same cycle.
- R6: With the counter zeroed at the start, for `dir_d2m`=1 the bytes popped at the memory side equal `dev_count` minus the fill. For `dir_d2m`=0 the bytes pushed at the memory side equal `dev_count` plus the fill.
- R7: `flush` empties the buffer by the next cycle. While `flush` is high, both `in_ready` and `out_valid` are low.
- R8: After `abort`, both ports stay idle and the contents are kept until `start`. The data that follows `start` is the data held before the abort.
- R9: After `stop`, `in_ready` stays low while the pop port keeps draining. `stopped` is high exactly while the stop is pending and the buffer is empty. `start` clears both the stop and the abort state.
- R10: With `mem_swap` set and the memory side at 32 bits, the four bytes of the memory-side word are reversed.
- R11: With `dev_swap` set and the device side at 16 or 32 bits, the two bytes of each 16-bit halfword on the device side are exchanged.
- R12: Take a 32-bit memory side feeding a 16-bit device side with both swaps set. A memory word with S1 in bits 31:16 and S0 in bits 15:0 yields device halfword S1 and then S0, each intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dir_d2m | input | 1 | 1: device pushes, memory pops; 0: memory pushes, device pops |
| dev_size | input | 2 | Device-side size code |
| mem_size | input | 2 | Memory-side size code |
| dev_swap | input | 1 | Halfword byte exchange on the device side |
| mem_swap | input | 1 | Word byte reversal on the memory side |
| flush | input | 1 | Empty the buffer |
| abort | input | 1 | Freeze both ports, keep contents |
| stop | input | 1 | Close push port and drain |
| start | input | 1 | Clear abort and stop state |
| in_valid | input | 1 | Push data valid |
| in_ready | output | 1 | Push accepted |
| in_data | input | 32 | Push data |
| out_valid | output | 1 | Pop data valid |
| out_ready | input | 1 | Pop consumer ready |
| out_data | output | 32 | Pop data |
| count_reg | output | 32 | Free and filled byte counts |
| dcnt_we | input | 1 | Load device byte counter |
| dcnt_wdata | input | 32 | Value for device byte counter |
| dev_count | output | 32 | Device-side byte counter |
| stopped | output | 1 | Stop pending and buffer empty |

## Verification
The push and the pop can fire in the same cycle, often with unequal widths. The fill must then move by the net difference. The random phases hold both ports busy with independent random valid/ready patterns at mixed widths, and every cycle the bench compares the count word against its own byte queue. A second collision, a counter write landing on a cycle that also moves device-side bytes, is forced directly. It is judged by the counter holding exactly the written value afterwards.

// File: rtl/dma_stage_fifo.sv
module dma_stage_fifo #(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dir_d2m,
  input  logic [1:0]  dev_size,
  input  logic [1:0]  mem_size,
  input  logic        dev_swap,
  input  logic        mem_swap,
  input  logic        flush,
  input  logic        abort,
  input  logic        stop,
  input  logic        start,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_data,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_data,
  output logic [31:0] count_reg,
  input  logic        dcnt_we,
  input  logic [31:0] dcnt_wdata,
  output logic [31:0] dev_count,
  output logic        stopped
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  function automatic logic [CW-1:0] width_bytes(logic [1:0] code);
    case (code)
      2'd1:    return CW'(1);
      2'd2:    return CW'(2);
      2'd3:    return CW'(4);
      default: return '0;
    endcase
  endfunction

  function automatic logic [31:0] lane_swap(logic [31:0] d, logic is_mem, logic [1:0] code,
                                            logic msw, logic dsw);
    if (is_mem && msw && code == 2'd3) return {d[7:0], d[15:8], d[23:16], d[31:24]};
    if (!is_mem && dsw && code >= 2'd2) return {d[23:16], d[31:24], d[7:0], d[15:8]};
    return d;
  endfunction

  function automatic logic [PW-1:0] wrap(int s);
    return PW'(s >= DEPTH ? s - DEPTH : s);
  endfunction

  logic [7:0]    store [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] fill, free, n_in, n_out;
  logic          halted, stopping;
  logic [1:0]    in_code, out_code;
  logic          push, pop;
  logic [31:0]   in_sw, raw;

  assign in_code  = dir_d2m ? dev_size : mem_size;
  assign out_code = dir_d2m ? mem_size : dev_size;
  assign n_in     = width_bytes(in_code);
  assign n_out    = width_bytes(out_code);
  assign free     = CW'(DEPTH) - fill;

  assign in_ready  = !halted && !stopping && !flush && n_in != '0 && free >= n_in;
  assign out_valid = !halted && !flush && n_out != '0 && fill >= n_out;
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;
  assign stopped   = stopping && fill == '0;
  assign count_reg = (32'(free) << 16) | 32'(fill);

  assign in_sw = lane_swap(in_data, !dir_d2m, in_code, mem_swap, dev_swap);

  always_comb begin
    for (int k = 0; k < 4; k++)
      raw[8*k +: 8] = (k < int'(n_out)) ? store[wrap(int'(rp) + k)] : 8'h00;
  end
  assign out_data = lane_swap(raw, dir_d2m, out_code, mem_swap, dev_swap);

  always_ff @(posedge clk) begin
    if (push)
      for (int k = 0; k < 4; k++)
        if (k < int'(n_in)) store[wrap(int'(wp) + k)] <= in_sw[8*k +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; fill <= '0;
      halted <= 1'b0; stopping <= 1'b0; dev_count <= '0;
    end else begin
      if (flush) begin
        wp <= '0; rp <= '0; fill <= '0;
      end else begin
        if (push) wp <= wrap(int'(wp) + int'(n_in));
        if (pop)  rp <= wrap(int'(rp) + int'(n_out));
        fill <= fill + (push ? n_in : '0) - (pop ? n_out : '0);
      end
      if (start) begin
        halted <= 1'b0; stopping <= 1'b0;
      end else begin
        if (abort) halted <= 1'b1;
        if (stop)  stopping <= 1'b1;
      end
      if (dcnt_we)             dev_count <= dcnt_wdata;
      else if (dir_d2m && push) dev_count <= dev_count + 32'(n_in);
      else if (!dir_d2m && pop) dev_count <= dev_count + 32'(n_out);
    end
  end

  // R1
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) fill <= CW'(DEPTH));
  // R7
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n) flush |=> count_reg[7:0] == 8'd0);
  // R8
  abort_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !flush && !start) |=> $stable(count_reg));
  // R5
  dcnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dcnt_we |=> dev_count == $past(dcnt_wdata));
  // R9
  stop_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> !in_ready);
  // R3
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_reg[7:0] == 8'd0) |-> !out_valid);
endmodule

// File: tb/dma_stage_fifo_bench.sv
module dma_stage_fifo_bench;
  localparam int DEPTH = 64;
  logic clk = 1'b0, rst_n = 1'b0;
  logic dir_d2m = 1'b1, dev_swap = 1'b0, mem_swap = 1'b0;
  logic [1:0] dev_size = 2'd1, mem_size = 2'd1;
  logic flush = 0, abort = 0, stop = 0, start = 0;
  logic in_valid = 0, out_ready = 0, dcnt_we = 0;
  logic [31:0] in_data = 0, dcnt_wdata = 0;
  logic in_ready, out_valid, stopped;
  logic [31:0] out_data, count_reg, dev_count;

  dma_stage_fifo #(.DEPTH(DEPTH)) u_dma_stage_fifo (
    .clk, .rst_n, .dir_d2m, .dev_size, .mem_size, .dev_swap, .mem_swap,
    .flush, .abort, .stop, .start, .in_valid, .in_ready, .in_data,
    .out_valid, .out_ready, .out_data, .count_reg, .dcnt_we, .dcnt_wdata,
    .dev_count, .stopped);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] q[$];
  bit mh = 0, ms = 0;
  logic [31:0] devc = 0, membytes = 0, last_out = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int nb(logic [1:0] c);
    case (c) 2'd1: return 1; 2'd2: return 2; 2'd3: return 4; default: return 0; endcase
  endfunction

  function automatic logic [31:0] bswz(logic [31:0] d, bit mem, logic [1:0] c, bit msw, bit dsw);
    if (mem && msw && c == 2'd3) return {d[7:0], d[15:8], d[23:16], d[31:24]};
    if (!mem && dsw && c >= 2'd2) return {d[23:16], d[31:24], d[7:0], d[15:8]};
    return d;
  endfunction

  task automatic cyc();
    logic [1:0] ic, oc;
    int ni, no;
    bit er, ev, pf, of;
    logic [31:0] w, sw;
    ic = dir_d2m ? dev_size : mem_size;
    oc = dir_d2m ? mem_size : dev_size;
    ni = nb(ic); no = nb(oc);
    #1;
    er = !mh && !ms && !flush && ni != 0 && (DEPTH - q.size()) >= ni;
    ev = !mh && !flush && no != 0 && q.size() >= no;
    chk("R3 R7 in_ready", 32'(in_ready), 32'(er));
    chk("R3 R7 out_valid", 32'(out_valid), 32'(ev));
    pf = in_valid && er;
    of = out_ready && ev;
    if (of) begin
      w = 0;
      for (int k = 0; k < no; k++) w[8*k +: 8] = q[k];
      chk("R2 R10 R11 out_data", out_data, bswz(w, dir_d2m, oc, mem_swap, dev_swap));
      last_out = out_data;
    end
    @(posedge clk);
    if (dcnt_we) devc = dcnt_wdata;
    else if (dir_d2m && pf) devc += 32'(ni);
    else if (!dir_d2m && of) devc += 32'(no);
    if (dir_d2m && of) membytes += 32'(no);
    if (!dir_d2m && pf) membytes += 32'(ni);
    if (flush) q.delete();
    else begin
      if (of) for (int k = 0; k < no; k++) void'(q.pop_front());
      if (pf) begin
        sw = bswz(in_data, !dir_d2m, ic, mem_swap, dev_swap);
        for (int k = 0; k < ni; k++) q.push_back(sw[8*k +: 8]);
      end
    end
    if (start) begin mh = 0; ms = 0; end
    else begin if (abort) mh = 1; if (stop) ms = 1; end
    @(negedge clk);
    chk("R1 R4 count_reg", count_reg, (32'(DEPTH - q.size()) << 16) | 32'(q.size()));
    chk("R5 dev_count", dev_count, devc);
    chk("R9 stopped", 32'(stopped), 32'(ms && q.size() == 0));
  endtask

  task automatic idle();
    in_valid = 0; out_ready = 0; flush = 0; abort = 0; stop = 0; start = 0; dcnt_we = 0;
  endtask

  task automatic clear_all();
    idle(); flush = 1; dcnt_we = 1; dcnt_wdata = 0; start = 1; cyc();
    idle(); membytes = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset count_reg", count_reg, 32'(DEPTH) << 16);
    chk("R5 reset dev_count", dev_count, 0);

    for (int p = 0; p < 10; p++) begin
      dir_d2m = $urandom_range(0, 1);
      dev_size = 2'($urandom_range(1, 3)); mem_size = 2'($urandom_range(1, 3));
      dev_swap = $urandom_range(0, 1); mem_swap = $urandom_range(0, 1);
      clear_all();
      for (int i = 0; i < 400; i++) begin
        in_valid = ($urandom_range(0, 3) != 0);
        out_ready = ($urandom_range(0, 2) != 0);
        in_data = $urandom;
        if (i % 97 == 50) dev_size = 2'($urandom_range(1, 3));
        cyc();
      end
      idle();
      if (dir_d2m) chk("R6 memory delivered", membytes, dev_count - 32'(count_reg[7:0]));
      else         chk("R6 memory fetched", membytes, dev_count + 32'(count_reg[7:0]));
    end

    // R3: fill to capacity with byte pushes
    dir_d2m = 1; dev_size = 1; mem_size = 3; dev_swap = 0; mem_swap = 0;
    clear_all();
    for (int i = 0; i < DEPTH + 2; i++) begin in_valid = 1; in_data = 32'(i); cyc(); end
    chk("R3 full count", count_reg, 32'(DEPTH));
    chk("R3 full blocks push", 32'(in_ready), 0);
    // R2: size code 0 idles the pop port
    mem_size = 0; in_valid = 0; out_ready = 1; cyc();
    chk("R2 code0 no pop", 32'(out_valid), 0);
    mem_size = 3;

    // R7: flush with a push in the same cycle
    flush = 1; in_valid = 1; out_ready = 0; cyc(); idle();
    chk("R7 flush empties", count_reg, 32'(DEPTH) << 16);

    // R5: counter write collides with a device-side push
    dev_size = 3; in_valid = 1; dcnt_we = 1; dcnt_wdata = 32'd100; in_data = 32'hCAFEF00D; cyc(); idle();
    chk("R5 write wins", dev_count, 32'd100);

    // R8: abort holds contents, start resumes with same data
    in_valid = 1; in_data = 32'h0BADBEEF; cyc(); idle();
    abort = 1; cyc(); idle();
    for (int i = 0; i < 5; i++) begin in_valid = 1; out_ready = 1; cyc(); end
    idle();
    chk("R8 contents kept", count_reg, (32'(DEPTH - 8) << 16) | 32'd8);
    start = 1; cyc(); idle();
    out_ready = 1; cyc(); idle();
    chk("R8 first word after start", last_out, 32'hCAFEF00D);

    // R9: stop drains then flags
    stop = 1; cyc(); idle();
    chk("R9 not yet stopped", 32'(stopped), 0);
    for (int i = 0; i < 3; i++) begin in_valid = 1; out_ready = 1; cyc(); end
    idle();
    chk("R9 stopped when empty", 32'(stopped), 1);
    start = 1; cyc(); idle();
    chk("R9 start clears", 32'(stopped), 0);

    // R10: memory-side reversal
    dir_d2m = 1; dev_size = 3; mem_size = 3; mem_swap = 1; dev_swap = 0; clear_all();
    in_valid = 1; in_data = 32'h11223344; cyc(); idle();
    out_ready = 1; cyc(); idle();
    chk("R10 reversed", last_out, 32'h44332211);

    // R11: device-side halfword exchange
    dev_size = 2; mem_size = 2; mem_swap = 0; dev_swap = 1; clear_all();
    in_valid = 1; in_data = 32'h0000ABCD; cyc(); idle();
    out_ready = 1; cyc(); idle();
    chk("R11 halfword swapped", last_out, 32'h0000CDAB);

    // R12: 32-bit memory to 16-bit device, both swaps
    dir_d2m = 0; mem_size = 3; dev_size = 2; mem_swap = 1; dev_swap = 1; clear_all();
    in_valid = 1; in_data = 32'h12345678; cyc(); idle();
    out_ready = 1; cyc();
    chk("R12 first sample", last_out, 32'h00001234);
    cyc(); idle();
    chk("R12 second sample", last_out, 32'h00005678);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule